// File: doc/BRIEF.md
# Shadow RAM Segment Decoder

This block sets how the upper memory window from C0000h to FFFFFh is routed. It splits the window into eight 32 KB segments. Segment i starts at C0000h + i×8000h. Three configuration bytes control it: a shadow byte, a ROM-map byte and a control byte. From them the block works out, for every segment, where reads are served from and where writes land. The choices are internal shadow DRAM or the external bus. The block also works out which segments carry the ROM chip select, and two summary flags for the BIOS area (E0000h and up).

A 20-bit access address is decoded against the same configuration. The block returns a read route code and a write route code for that access. All outputs are registered. A change to any input is visible one clock later. The configuration bus and the memory arrays are outside this block.

Top module: `shadow_seg_decoder`

## Requirements
- R1: While rst_n is low, every output is zero. This means all segment vectors and both flags are 0, and both access route codes are 00.
- R2: The ROM chip-select vector segRomCs always has bits 6 and 7 set. cfgRomMap bit 6 adds segment 0, cfgRomMap bit 7 adds segments 4 and 5, and cfgCtrl bit 2 adds segment 1. Segments 2 and 3 never carry it.
- R3: Segments 6 and 7 are always under shadow control. A segment i below 6 is under shadow control only when cfgShadow bit i is 1.
- R4: A segment that is not under shadow control has segRdInt and segWrInt both 0. Its reads and writes go external.
- R5: For a segment under shadow control, segRdInt is 1 exactly when cfgShadow bit 7 is 1. segWrInt is 1 exactly when cfgShadow bit 6 is 0.
- R6: Route codes are 00 for internal DRAM, 01 for a plain external access and 10 for an external access to a segment whose ROM chip select is set. Code 11 never appears.
- R7: biosShadowRd is 1 when cfgShadow bit 7 is 1 and some segment 4 to 7 is under shadow control. biosWrProt is 1 under the same condition with cfgShadow bit 6.
- R8: Every output reflects the inputs sampled at the previous rising clock edge. A change in between does not show until that edge.
- R9: An access address below C0000h reports route 00 for both read and write.
- R10: An address inside the window selects segment (accAddr − C0000h) >> 15. accRdRoute and accWrRoute equal that segment's read and write routes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgShadow | input | 8 | Per-segment shadow enables (bits 0-5), read-internal (bit 7), write-external (bit 6) |
| cfgRomMap | input | 8 | ROM select extension: bit 6 segment 0, bit 7 segments 4 and 5 |
| cfgCtrl | input | 8 | Bit 2 adds segment 1 to the ROM select |
| accAddr | input | 20 | Access address to classify |
| segRdInt | output | 8 | Per-segment: reads served from internal DRAM |
| segWrInt | output | 8 | Per-segment: writes go to internal DRAM |
| segRomCs | output | 8 | Per-segment ROM chip select |
| biosShadowRd | output | 1 | BIOS area is shadowed for reads |
| biosWrProt | output | 1 | BIOS area is write protected |
| accRdRoute | output | 2 | Read route code for accAddr |
| accWrRoute | output | 2 | Write route code for accAddr |

## Verification
The bench first walks every segment under a fixed configuration. This separates the per-segment enable from the forced top two segments. It then sets each ROM-map bit on its own, so a bit wired to the wrong segment shows up as a route code of 01 where 10 was expected. Configurations with the read and write mode bits in all four combinations separate an inverted mode bit from a swapped one. Addresses below the window and random mixes of the three bytes cover the out-of-range default and the index arithmetic. A held-back configuration change checks the one-cycle update.

// File: rtl/shadow_seg_pkg.sv
package shadow_seg_pkg;
  localparam int SEG_COUNT      = 8;
  localparam int FORCED_FROM    = 6;  // segments at/above this index are always shadow controlled
  localparam int RD_INT_BIT     = 7;
  localparam int WR_EXT_BIT     = 6;
  localparam int MAP_SEG0_BIT   = 6;
  localparam int MAP_SEG45_BIT  = 7;
  localparam int CTRL_SEG1_BIT  = 2;

  typedef enum logic [1:0] {
    ROUTE_INT     = 2'b00,
    ROUTE_EXT     = 2'b01,
    ROUTE_EXT_ANY = 2'b10
  } route_e;

  typedef struct packed {
    logic [SEG_COUNT-1:0] shadowCtl;
    logic [SEG_COUNT-1:0] romCs;
    logic                 readInternal;
    logic                 writeExternal;
  } seg_strobe_t;
endpackage

// File: rtl/shadow_seg_ctrl.sv
module shadow_seg_ctrl
  import shadow_seg_pkg::*;
(
  input  logic [7:0]  cfgShadow,
  input  logic [7:0]  cfgRomMap,
  input  logic [7:0]  cfgCtrl,
  output seg_strobe_t strobes
);
  logic [SEG_COUNT-1:0] ctlVec;
  logic [SEG_COUNT-1:0] romVec;

  genvar gi;
  generate
    for (gi = 0; gi < SEG_COUNT; gi++) begin : gSeg
      if (gi >= FORCED_FROM) begin : gForced
        assign ctlVec[gi] = 1'b1;
        assign romVec[gi] = 1'b1;
      end else begin : gProg
        assign ctlVec[gi] = cfgShadow[gi];
        if (gi == 0) begin : gR0
          assign romVec[gi] = cfgRomMap[MAP_SEG0_BIT];
        end else if (gi == 1) begin : gR1
          assign romVec[gi] = cfgCtrl[CTRL_SEG1_BIT];
        end else if (gi == 4 || gi == 5) begin : gR45
          assign romVec[gi] = cfgRomMap[MAP_SEG45_BIT];
        end else begin : gRn
          assign romVec[gi] = 1'b0;
        end
      end
    end
  endgenerate

  always_comb begin
    strobes.shadowCtl     = ctlVec;
    strobes.romCs         = romVec;
    strobes.readInternal  = cfgShadow[RD_INT_BIT];
    strobes.writeExternal = cfgShadow[WR_EXT_BIT];
  end
endmodule

// File: rtl/shadow_seg_datapath.sv
module shadow_seg_datapath
  import shadow_seg_pkg::*;
#(
  parameter int                ADDR_W         = 20,
  parameter int                SEG_SHIFT      = 15,
  parameter logic [ADDR_W-1:0] REGION_BASE    = 20'hC0000,
  parameter int                BIOS_FIRST_SEG = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  seg_strobe_t          strobes,
  input  logic [ADDR_W-1:0]    accAddr,
  output logic [SEG_COUNT-1:0] segRdInt,
  output logic [SEG_COUNT-1:0] segWrInt,
  output logic [SEG_COUNT-1:0] segRomCs,
  output logic                 biosShadowRd,
  output logic                 biosWrProt,
  output logic [1:0]           accRdRoute,
  output logic [1:0]           accWrRoute
);
  localparam int IDX_W = $clog2(SEG_COUNT);

  route_e               rdRouteSeg [SEG_COUNT];
  route_e               wrRouteSeg [SEG_COUNT];
  logic [SEG_COUNT-1:0] rdIntNext;
  logic [SEG_COUNT-1:0] wrIntNext;
  logic [SEG_COUNT-1:0] biosMask;

  genvar gi;
  generate
    for (gi = 0; gi < SEG_COUNT; gi++) begin : gSeg
      route_e extType;
      assign extType        = strobes.romCs[gi] ? ROUTE_EXT_ANY : ROUTE_EXT;
      assign rdIntNext[gi]  = strobes.shadowCtl[gi] & strobes.readInternal;
      assign wrIntNext[gi]  = strobes.shadowCtl[gi] & ~strobes.writeExternal;
      assign rdRouteSeg[gi] = rdIntNext[gi] ? ROUTE_INT : extType;
      assign wrRouteSeg[gi] = wrIntNext[gi] ? ROUTE_INT : extType;
      assign biosMask[gi]   = (gi >= BIOS_FIRST_SEG);
    end
  endgenerate

  logic              inRange;
  logic [ADDR_W-1:0] offset;
  logic [IDX_W-1:0]  segIdx;
  route_e            rdNext, wrNext;
  logic              biosCtl;

  always_comb begin
    inRange = (accAddr >= REGION_BASE);
    offset  = accAddr - REGION_BASE;
    segIdx  = offset[SEG_SHIFT +: IDX_W];
    rdNext  = inRange ? rdRouteSeg[segIdx] : ROUTE_INT;
    wrNext  = inRange ? wrRouteSeg[segIdx] : ROUTE_INT;
    biosCtl = |(strobes.shadowCtl & biosMask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      segRdInt     <= '0;
      segWrInt     <= '0;
      segRomCs     <= '0;
      biosShadowRd <= 1'b0;
      biosWrProt   <= 1'b0;
      accRdRoute   <= ROUTE_INT;
      accWrRoute   <= ROUTE_INT;
    end else begin
      segRdInt     <= rdIntNext;
      segWrInt     <= wrIntNext;
      segRomCs     <= strobes.romCs;
      biosShadowRd <= biosCtl & strobes.readInternal;
      biosWrProt   <= biosCtl & strobes.writeExternal;
      accRdRoute   <= rdNext;
      accWrRoute   <= wrNext;
    end
  end
endmodule

// File: rtl/shadow_seg_decoder.sv
module shadow_seg_decoder
  import shadow_seg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  cfgShadow,
  input  logic [7:0]  cfgRomMap,
  input  logic [7:0]  cfgCtrl,
  input  logic [19:0] accAddr,
  output logic [7:0]  segRdInt,
  output logic [7:0]  segWrInt,
  output logic [7:0]  segRomCs,
  output logic        biosShadowRd,
  output logic        biosWrProt,
  output logic [1:0]  accRdRoute,
  output logic [1:0]  accWrRoute
);
  seg_strobe_t strobes;

  shadow_seg_ctrl ctrl_i (
    .cfgShadow (cfgShadow),
    .cfgRomMap (cfgRomMap),
    .cfgCtrl   (cfgCtrl),
    .strobes   (strobes)
  );

  shadow_seg_datapath #(
    .ADDR_W         (20),
    .SEG_SHIFT      (15),
    .REGION_BASE    (20'hC0000),
    .BIOS_FIRST_SEG (4)
  ) dp_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobes      (strobes),
    .accAddr      (accAddr),
    .segRdInt     (segRdInt),
    .segWrInt     (segWrInt),
    .segRomCs     (segRomCs),
    .biosShadowRd (biosShadowRd),
    .biosWrProt   (biosWrProt),
    .accRdRoute   (accRdRoute),
    .accWrRoute   (accWrRoute)
  );
endmodule

// File: rtl/shadow_seg_decoder_chk.sv
module shadow_seg_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  cfgShadow,
  input logic [7:0]  cfgRomMap,
  input logic [7:0]  cfgCtrl,
  input logic [19:0] accAddr,
  input logic [7:0]  segRdInt,
  input logic [7:0]  segWrInt,
  input logic [7:0]  segRomCs,
  input logic        biosShadowRd,
  input logic        biosWrProt,
  input logic [1:0]  accRdRoute,
  input logic [1:0]  accWrRoute
);
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (segRdInt == 8'h00 && segWrInt == 8'h00 && segRomCs == 8'h00 && accRdRoute == 2'b00));

  a_r2_fixed_rom: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> segRomCs[7:6] == 2'b11 && segRomCs[3:2] == 2'b00);

  a_r4_uncontrolled_ext: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgShadow[2] |=> !segRdInt[2] && !segWrInt[2]);

  a_r6_no_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |-> accRdRoute != 2'b11 && accWrRoute != 2'b11);

  a_r7_flags: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> biosShadowRd == $past(cfgShadow[7]) && biosWrProt == $past(cfgShadow[6]));

  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> segRomCs[0] == $past(cfgRomMap[6]) && segRomCs[1] == $past(cfgCtrl[2]));

  a_r9_below_window: assert property (@(posedge clk) disable iff (!rst_n)
    accAddr < 20'hC0000 |=> accRdRoute == 2'b00 && accWrRoute == 2'b00);
endmodule

bind shadow_seg_decoder shadow_seg_decoder_chk chk_i (.*);

// File: tb/shadow_seg_decoder_tb.sv
module shadow_seg_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfgShadow = 8'h00, cfgRomMap = 8'h00, cfgCtrl = 8'h00;
  logic [19:0] accAddr = 20'h00000;
  logic [7:0]  segRdInt, segWrInt, segRomCs;
  logic        biosShadowRd, biosWrProt;
  logic [1:0]  accRdRoute, accWrRoute;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  shadow_seg_decoder dut_i (.*);

  typedef struct {
    logic [7:0] rd, wr, rom;
    logic       fRd, fWp;
    logic [1:0] aRd, aWr;
    bit         inWin;
  } exp_t;

  exp_t q[$];

  function automatic exp_t model(input [7:0] s, input [7:0] m, input [7:0] c, input [19:0] a);
    exp_t e;
    logic [7:0] ctl;
    int idx;
    e.rom = 8'hC0;                          // R2
    if (m[6]) e.rom[0] = 1'b1;
    if (m[7]) e.rom[5:4] = 2'b11;
    if (c[2]) e.rom[1] = 1'b1;
    ctl = {2'b11, s[5:0]};                  // R3
    e.rd = ctl & {8{s[7]}};                 // R4 R5
    e.wr = ctl & {8{~s[6]}};
    e.fRd = s[7] & |ctl[7:4];               // R7
    e.fWp = s[6] & |ctl[7:4];
    e.inWin = (a >= 20'hC0000);
    if (!e.inWin) begin                     // R9
      e.aRd = 2'b00; e.aWr = 2'b00;
    end else begin                          // R10 R6
      idx = int'((a - 20'hC0000) >> 15);
      e.aRd = e.rd[idx] ? 2'b00 : (e.rom[idx] ? 2'b10 : 2'b01);
      e.aWr = e.wr[idx] ? 2'b00 : (e.rom[idx] ? 2'b10 : 2'b01);
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input [7:0] s, input [7:0] m, input [7:0] c, input [19:0] a);
    @(negedge clk);
    cfgShadow = s; cfgRomMap = m; cfgCtrl = c; accAddr = a;
    q.push_back(model(s, m, c, a));
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(segRomCs == e.rom, "R2", "segRomCs", {8'h0, segRomCs}, {8'h0, e.rom});
        check(segRdInt == e.rd, "R3/R4/R5", "segRdInt", {8'h0, segRdInt}, {8'h0, e.rd});
        check(segWrInt == e.wr, "R3/R4/R5", "segWrInt", {8'h0, segWrInt}, {8'h0, e.wr});
        check({biosShadowRd, biosWrProt} == {e.fRd, e.fWp}, "R7", "flags",
              {14'h0, biosShadowRd, biosWrProt}, {14'h0, e.fRd, e.fWp});
        check(accRdRoute == e.aRd, e.inWin ? "R6/R10" : "R9", "accRdRoute",
              {14'h0, accRdRoute}, {14'h0, e.aRd});
        check(accWrRoute == e.aWr, e.inWin ? "R6/R10" : "R9", "accWrRoute",
              {14'h0, accWrRoute}, {14'h0, e.aWr});
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    // R1: reset state, inputs nonzero during reset
    cfgShadow = 8'hFF; cfgRomMap = 8'hFF; cfgCtrl = 8'hFF; accAddr = 20'hF0000;
    repeat (3) @(posedge clk);
    #2;
    check({segRdInt, segWrInt} == 16'h0, "R1", "seg vectors", {segRdInt, segWrInt}, 16'h0);
    check(segRomCs == 8'h0 && !biosShadowRd && !biosWrProt, "R1", "rom/flags",
          {6'h0, biosShadowRd, biosWrProt, segRomCs}, 16'h0);
    check(accRdRoute == 2'b00 && accWrRoute == 2'b00, "R1", "routes",
          {12'h0, accRdRoute, accWrRoute}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: walk all segments, default config
    for (int i = 0; i < 8; i++) drive(8'h00, 8'h00, 8'h00, 20'hC0000 + 20'(i) * 20'h8000 + 20'h123);
    // R3: segment enables with read-internal, write-internal; bits 6/7 are mode bits
    for (int i = 0; i < 8; i++) drive(8'h95, 8'h00, 8'h00, 20'hC0000 + 20'(i) * 20'h8000);
    // R5: all four mode combinations on an enabled segment and forced segment
    for (int md = 0; md < 4; md++) begin
      drive({md[1:0], 6'h3F}, 8'h00, 8'h00, 20'hD8000);
      drive({md[1:0], 6'h00}, 8'h00, 8'h00, 20'hFFFFF);
    end
    // R2 R6: each ROM-map bit alone
    drive(8'h00, 8'h40, 8'h00, 20'hC0000);
    drive(8'h00, 8'h80, 8'h00, 20'hE8000);
    drive(8'h00, 8'h80, 8'h00, 20'hE0000);
    drive(8'h00, 8'h00, 8'h04, 20'hCFFFF);
    drive(8'h00, 8'h3F, 8'hFB, 20'hD0000);
    drive(8'h40, 8'hFF, 8'hFF, 20'hC8000);
    // R7: BIOS flags
    drive(8'hC0, 8'h00, 8'h00, 20'h00000);
    drive(8'h80, 8'h00, 8'h00, 20'hBFFFF);
    // R9: below window
    drive(8'hBF, 8'hFF, 8'hFF, 20'hA0000);
    drive(8'h3F, 8'hFF, 8'hFF, 20'h12345);
    // random mixes
    for (int k = 0; k < 200; k++)
      drive(8'($urandom), 8'($urandom), 8'($urandom), 20'($urandom));
    @(negedge clk);
    @(posedge clk); #3;

    // R8: change between edges is not visible until the next edge
    @(negedge clk);
    cfgShadow = 8'h80; cfgRomMap = 8'h00; cfgCtrl = 8'h00; accAddr = 20'hF0000;
    @(posedge clk); #2;
    @(negedge clk);
    cfgShadow = 8'h40; cfgRomMap = 8'h40; accAddr = 20'hC0000;
    #2;
    check(biosShadowRd == 1'b1 && biosWrProt == 1'b0, "R8", "flags held before edge",
          {14'h0, biosShadowRd, biosWrProt}, 16'h0002);
    check(accRdRoute == 2'b00 && segRomCs[0] == 1'b0, "R8", "route held before edge",
          {7'h0, segRomCs[0], 6'h0, accRdRoute}, 16'h0000);
    @(posedge clk); #2;
    check(biosShadowRd == 1'b0 && biosWrProt == 1'b1, "R8", "flags after edge",
          {14'h0, biosShadowRd, biosWrProt}, 16'h0001);
    check(accRdRoute == 2'b10 && segRomCs[0] == 1'b1, "R8", "route after edge",
          {7'h0, segRomCs[0], 6'h0, accRdRoute}, 16'h0102);

    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule